// File: doc/BRIEF.md
# External Interrupt Source Selector

This block is a small memory-mapped configuration register set. Its main job is to pick, for each of sixteen external-interrupt lines, which of nine GPIO ports drives that line. The pin levels of all nine ports come in on one 144-bit vector. Bit `port*16 + pin` carries the level of that pin. Sixteen level outputs leave the block, one for each interrupt line. Line `n` always comes from pin `n` of some port. A 4-bit port number held in a packed select register chooses which port. The routing is purely combinational, so a line output follows its selected pin in the same cycle.

Software reaches the registers over a plain 32-bit bus with an address, a write enable, write data and read data. Writes take effect at the rising clock edge. Reads are combinational from the current address. The bus has no handshake: every access completes in one cycle, so there is no back-pressure to manage. The register set has these parts:
- four port-select registers;
- a compensation-control register that stores everything written to it;
- two legacy registers, memory remap and peripheral mode, that accept writes and ignore them.

Top module: `exti_route_top`

## Requirements
- R1: After reset every register reads zero: memory remap (0x00), peripheral mode (0x04), the four port-select registers and compensation control (0x20). All select fields are therefore zero, so every line follows port 0.
- R2: Line `n` output equals input bit `port*16 + n` when its 4-bit field holds `port` in 0..8. The field is in the port-select register at offset `0x08 + 4*(n/4)`, bits `[(n%4)*4 +: 4]`.
- R3: A line output ignores every pin input other than the one its field selects, including the same pin number on other ports.
- R4: A select field holding 9..15 selects no port, and the line output is low whatever the pins do.
- R5: A write to a port-select register stores only the low 16 bits of the write data. Bits 31:16 of that register always read zero.
- R6: Writes to offsets 0x00 and 0x04 have no effect. Both always read zero.
- R7: The compensation-control register at 0x20 stores all 32 bits of a write and reads them back.
- R8: Within the 0x400-byte window, any offset not listed above reads zero, and a write to it changes no register. Offsets that are not word-aligned count as unlisted.
- R9: A register write becomes visible on read data and on line outputs in the cycle after the clock edge that takes it. Read data and line outputs follow address and pin changes with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Byte offset within the register window |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_lvl | input | 144 | Pin levels, bit `port*16 + pin` |
| line_out | output | 16 | Interrupt line levels, one per line number |

## Verification
The assertions assume that the bus drives a known address every cycle. They also assume that no write is issued during reset, so the first cycle after reset has no earlier write to refer to. The read-back properties assume that the address is held for the cycle after a write, and the output-stability property assumes that the pins change only when the bench drives them. The bench drives address, strobe and pins on the falling edge and issues writes only after reset is released. It holds the address across the cycle after each write and leaves the pins untouched between intended changes.

// File: rtl/exti_route_pkg.sv
package exti_route_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 10;
  localparam int FLD_PER_REG = 4;

  localparam logic [ADDR_W-1:0] OFS_REMAP    = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_PMODE    = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_SEL_BASE = 10'h008;
  localparam logic [ADDR_W-1:0] OFS_COMP     = 10'h020;

  function automatic logic [ADDR_W-1:0] sel_ofs(input int idx);
    return OFS_SEL_BASE + ADDR_W'(4 * idx);
  endfunction
endpackage

// File: rtl/exti_cfg_regs.sv
module exti_cfg_regs
  import exti_route_pkg::*;
#(
  parameter int NUM_SEL  = 4,
  parameter int SEL_BITS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wr_en,
  input  logic [BUS_W-1:0]             wr_data,
  output logic [BUS_W-1:0]             rd_data,
  output logic [NUM_SEL*SEL_BITS-1:0]  sel_bus
);
  logic [NUM_SEL*SEL_BITS-1:0] sel_q;
  logic [BUS_W-1:0]            comp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      comp_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_SEL; k++) begin
        if (addr == sel_ofs(k)) sel_q[k*SEL_BITS +: SEL_BITS] <= wr_data[SEL_BITS-1:0];
      end
      if (addr == OFS_COMP) comp_q <= wr_data;
    end
  end

  // Remap and mode offsets decode but hold no state: they always read zero.
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (addr == sel_ofs(k)) rd_data = BUS_W'(sel_q[k*SEL_BITS +: SEL_BITS]);
    end
    if (addr == OFS_COMP) rd_data = comp_q;
  end

  assign sel_bus = sel_q;
endmodule

// File: rtl/exti_line_pick.sv
module exti_line_pick #(
  parameter int NUM_PORTS = 9,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_PORTS-1:0] col,
  input  logic [SEL_W-1:0]     field,
  output logic                 lvl
);
  always_comb begin
    lvl = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (field == SEL_W'(p)) lvl = col[p];
    end
  end
endmodule

// File: rtl/exti_line_mux.sv
module exti_line_mux #(
  parameter int NUM_PORTS = 9,
  parameter int LINES     = 16,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_PORTS*LINES-1:0] pin_lvl,
  input  logic [LINES*SEL_W-1:0]     sel_bus,
  output logic [LINES-1:0]           line_out
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [NUM_PORTS-1:0] col;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign col[p] = pin_lvl[p*LINES + l];
    end
    exti_line_pick #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_pick (
      .col   (col),
      .field (sel_bus[l*SEL_W +: SEL_W]),
      .lvl   (line_out[l])
    );
  end
endmodule

// File: rtl/exti_route_top.sv
module exti_route_top
  import exti_route_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int LINES     = 16,
  parameter int SEL_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic [BUS_W-1:0]           wr_data,
  output logic [BUS_W-1:0]           rd_data,
  input  logic [NUM_PORTS*LINES-1:0] pin_lvl,
  output logic [LINES-1:0]           line_out
);
  localparam int NUM_SEL  = LINES / FLD_PER_REG;
  localparam int SEL_BITS = FLD_PER_REG * SEL_W;

  logic [LINES*SEL_W-1:0] sel_bus;

  exti_cfg_regs #(.NUM_SEL(NUM_SEL), .SEL_BITS(SEL_BITS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .sel_bus (sel_bus)
  );

  exti_line_mux #(.NUM_PORTS(NUM_PORTS), .LINES(LINES), .SEL_W(SEL_W)) u_mux (
    .pin_lvl  (pin_lvl),
    .sel_bus  (sel_bus),
    .line_out (line_out)
  );
endmodule

// File: rtl/exti_route_chk.sv
module exti_route_chk
  import exti_route_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int LINES     = 16,
  parameter int SEL_W     = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          addr,
  input logic                       wr_en,
  input logic [BUS_W-1:0]           wr_data,
  input logic [BUS_W-1:0]           rd_data,
  input logic [NUM_PORTS*LINES-1:0] pin_lvl,
  input logic [LINES-1:0]           line_out,
  input logic [LINES*SEL_W-1:0]     sel_bus
);
  localparam int NUM_SEL = LINES / FLD_PER_REG;

  logic is_sel, mapped;
  always_comb begin
    is_sel = 1'b0;
    for (int k = 0; k < NUM_SEL; k++) if (addr == sel_ofs(k)) is_sel = 1'b1;
    mapped = is_sel || addr == OFS_REMAP || addr == OFS_PMODE || addr == OFS_COMP;
  end

  p_legacy_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_REMAP || addr == OFS_PMODE) |-> rd_data == '0);

  p_sel_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_sel |-> rd_data[31:16] == 16'h0);

  p_sel_keep_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(addr) == OFS_SEL_BASE && addr == OFS_SEL_BASE)
      |-> rd_data == {16'h0, $past(wr_data[15:0])});

  p_comp_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(addr) == OFS_COMP && addr == OFS_COMP)
      |-> rd_data == $past(wr_data));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> rd_data == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(pin_lvl)) |-> $stable(line_out));

  for (genvar l = 0; l < LINES; l++) begin : g_bad
    p_bad_field_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_bus[l*SEL_W +: SEL_W] >= SEL_W'(NUM_PORTS)) |-> !line_out[l]);
  end
endmodule

bind exti_route_top exti_route_chk #(.NUM_PORTS(NUM_PORTS), .LINES(LINES), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .pin_lvl  (pin_lvl),
  .line_out (line_out),
  .sel_bus  (sel_bus)
);

// File: tb/exti_route_top_tb_top.sv
module exti_route_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 9;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [9:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NP*NL-1:0] pin_lvl = '0;
  logic [NL-1:0] line_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exti_route_top dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_lvl(pin_lvl), .line_out(line_out)
  );

  // {line, field, driven port, 3'b0, expected}
  localparam logic [15:0] TBL [10] = '{
    {4'd0,  4'd0,  4'd0, 4'd1}, {4'd0,  4'd1,  4'd0, 4'd0},
    {4'd5,  4'd3,  4'd3, 4'd1}, {4'd7,  4'd8,  4'd8, 4'd1},
    {4'd15, 4'd8,  4'd8, 4'd1}, {4'd10, 4'd2,  4'd5, 4'd0},
    {4'd12, 4'd9,  4'd0, 4'd0}, {4'd3,  4'd15, 4'd3, 4'd0},
    {4'd9,  4'd4,  4'd4, 4'd1}, {4'd14, 4'd6,  4'd6, 4'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] s0, s1, s2, s3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(10'h000, v); chk("R1 remap", v, 0);
    rd(10'h004, v); chk("R1 mode", v, 0);
    for (int k = 0; k < 4; k++) begin
      rd(10'h008 + 10'(4*k), v); chk("R1 select", v, 0);
    end
    rd(10'h020, v); chk("R1 comp", v, 0);
    pin_lvl = '0; pin_lvl[5] = 1'b1;
    #1 chk("R1 port0 default", 32'(line_out), 32'h0020);
    pin_lvl = '0;

    // R2/R3/R4 table walk
    for (int i = 0; i < 10; i++) begin
      logic [3:0] ln, fld, prt;
      logic ex, ex_inv;
      ln = TBL[i][15:12]; fld = TBL[i][11:8]; prt = TBL[i][7:4]; ex = TBL[i][0];
      wr(10'h008 + 10'(4*(ln/4)), 32'(fld) << (4*(ln%4)));
      @(negedge clk);
      pin_lvl = '0; pin_lvl[prt*16 + ln] = 1'b1;
      #1 chk("R2 route one-hot", 32'(line_out[ln]), 32'(ex));
      pin_lvl = ~pin_lvl;
      ex_inv = (fld < 9) ? (fld != prt) : 1'b0;
      #1 chk("R3 R4 inverted pins", 32'(line_out[ln]), 32'(ex_inv));
      pin_lvl = '0;
    end

    // R4: all pins high, invalid field keeps line low
    wr(10'h00C, 32'h0000_F000);
    @(negedge clk); pin_lvl = '1;
    #1 chk("R4 field 15 all pins high", 32'(line_out[7]), 0);
    chk("R4 neighbour still routes", 32'(line_out[4]), 1);
    pin_lvl = '0;

    // R5
    wr(10'h010, 32'hDEAD_BEEF);
    rd(10'h010, v); chk("R5 low half kept", v, 32'h0000_BEEF);

    // R6
    wr(10'h000, 32'hFFFF_FFFF); rd(10'h000, v); chk("R6 remap ignored", v, 0);
    wr(10'h004, 32'h1234_5678); rd(10'h004, v); chk("R6 mode ignored", v, 0);

    // R7
    wr(10'h020, 32'hA5A5_5A5A); rd(10'h020, v); chk("R7 comp", v, 32'hA5A5_5A5A);
    wr(10'h020, 32'h8000_0001); rd(10'h020, v); chk("R7 comp", v, 32'h8000_0001);

    // R8
    rd(10'h008, s0); rd(10'h00C, s1); rd(10'h010, s2); rd(10'h014, s3);
    wr(10'h018, 32'hFFFF_FFFF); wr(10'h009, 32'hFFFF_FFFF); wr(10'h3FC, 32'hFFFF_FFFF);
    rd(10'h018, v); chk("R8 unmapped read", v, 0);
    rd(10'h009, v); chk("R8 unaligned read", v, 0);
    rd(10'h3FC, v); chk("R8 top read", v, 0);
    rd(10'h008, v); chk("R8 sel0 unchanged", v, s0);
    rd(10'h00C, v); chk("R8 sel1 unchanged", v, s1);
    rd(10'h010, v); chk("R8 sel2 unchanged", v, s2);
    rd(10'h014, v); chk("R8 sel3 unchanged", v, s3);
    rd(10'h020, v); chk("R8 comp unchanged", v, 32'h8000_0001);

    // R9: write timing and combinational paths
    @(negedge clk);
    addr = 10'h014; wr_data = 32'h0000_0700; wr_en = 1'b1;   // line 14 -> port 7
    pin_lvl = '0; pin_lvl[7*16 + 14] = 1'b1;
    #1 chk("R9 before edge", 32'(line_out[14]), 0);
    @(posedge clk); #1 wr_en = 1'b0;
    chk("R9 after edge", 32'(line_out[14]), 1);
    chk("R9 read after edge", rd_data, 32'h0000_0700);
    pin_lvl[7*16 + 14] = 1'b0;
    #1 chk("R9 pin change no clock", 32'(line_out[14]), 0);

    finish_run();
  end
endmodule